// File: doc/BRIEF.md
# Address Parity Checker with Tri-State Error Pulse

This block watches a 32-bit processor address bus that travels with four parity bits, one for each address byte. On every clock edge where the transfer start strobe is high and checking is switched on, it compares each address byte against its parity bit. If any byte disagrees, the block drives an active-low error line for exactly one cycle. In every other cycle the line is released to high impedance.

The pin is modelled as a drive value plus an output enable, so a pad cell or a shared open-drain style net can be built around it. Checking is switched on by holding an active-low enable input low. Address bit 0 is the most significant bit of the bus. Parity bit n belongs to address byte n. Parity is odd: across the eight address bits of a byte and its parity bit, the count of ones is odd.

Top module: `addr_parity_chk`

## Requirements
- R1: Parity bit `apar_i[n]` covers address bits `addr_i[8n]` to `addr_i[8n+7]`, where `addr_i[0]` is the most significant bit and `apar_i[0]` is the leftmost bit of the parity field. An error in byte n is judged against parity bit n only.
- R2: A byte is correct when its eight bits and its parity bit together hold an odd number of ones. An address with all four bytes correct produces no error pulse.
- R3: When the transfer start is high at a clock edge, the enable is low and at least one byte is wrong, then in the following cycle `err_oe_o` is 1 and `err_n_o` is 0.
- R4: The error pulse lasts one cycle. In the cycle after it, unless a new qualifying error was sampled, `err_oe_o` is 0 and `err_n_o` is 1.
- R5: While `chk_en_n_i` is high at the sampling edge, no error pulse is produced, whatever the address and parity are.
- R6: Address and parity values at an edge where the transfer start is low are ignored and produce no pulse.
- R7: Transfer starts on consecutive edges that each carry an error produce consecutive pulses, each in the cycle after its own start. The line stays driven low across them.
- R8: During and after reset, `err_oe_o` is 0 and `err_n_o` is 1. Reset is asynchronous and active low, and it also cuts a pulse already in flight.
- R9: Any number of wrong bytes, from one to all four, in a single transfer produces exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start_i | input | 1 | Transfer start strobe, active high |
| addr_i | input | 32 | Address bus, bit 0 is the MSB |
| apar_i | input | 4 | Odd parity bits, bit n for byte n |
| chk_en_n_i | input | 1 | Active-low check enable |
| err_n_o | output | 1 | Error pin drive value, low for an error |
| err_oe_o | output | 1 | Error pin output enable, 0 means high impedance |

## Verification
The bench flips single address bits inside each byte, with and without the matching parity bit. A design that pairs parity bits with the wrong bytes, or numbers the bus from the wrong end, misses an error or flags a correct address. Back-to-back erroring starts must keep the line low for two cycles. A design that alternates, or that stretches every pulse, shows up at the second cycle or in the cycle after the last pulse. The bench also checks that starts with checking disabled, and edges without a start, leave the pin released. An asynchronous reset during a pulse must release it at once.

// File: rtl/apc_pkg.sv
package apc_pkg;

    // Registered state of the error pin: drive enable and drive level.
    typedef struct packed {
        logic oe;
        logic lvl_n;
    } err_pin_t;

    localparam err_pin_t ERR_PIN_IDLE = '{oe: 1'b0, lvl_n: 1'b1};

endpackage

// File: rtl/apc_lane_chk.sv
// Parity check of one address byte against its own parity bit.
module apc_lane_chk #(
    parameter int LANE_W     = 8,
    parameter bit ODD_PARITY = 1'b1
) (
    input  logic [0:LANE_W-1] lane_i,
    input  logic              par_i,
    output logic              bad_o
);

    logic ones_odd;

    always_comb begin
        ones_odd = ^{lane_i, par_i};
    end

    generate
        if (ODD_PARITY) begin : g_odd
            always_comb bad_o = ~ones_odd;
        end else begin : g_even
            always_comb bad_o = ones_odd;
        end
    endgenerate

endmodule

// File: rtl/apc_pulse_ctl.sv
// Turns a qualified error into a one-cycle driven-low pulse on the pin.
module apc_pulse_ctl
    import apc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic oe_o,
    output logic lvl_n_o
);

    err_pin_t pin_d, pin_q;

    always_comb begin
        pin_d       = ERR_PIN_IDLE;
        pin_d.oe    = fire_i;
        pin_d.lvl_n = ~fire_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= ERR_PIN_IDLE;
        else        pin_q <= pin_d;
    end

    assign oe_o    = pin_q.oe;
    assign lvl_n_o = pin_q.lvl_n;

    // R3 / R7: a qualified error drives the pin low in the next cycle
    a_r3_pulse_next: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> (oe_o && !lvl_n_o));

    // R4: without a new error the pin is released after one cycle
    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_i |=> (!oe_o && lvl_n_o));

endmodule

// File: rtl/addr_parity_chk.sv
module addr_parity_chk
    import apc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LANE_W     = 8,
    parameter bit ODD_PARITY = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  xfer_start_i,
    input  logic [0:ADDR_W-1]     addr_i,
    input  logic [0:ADDR_W/LANE_W-1] apar_i,
    input  logic                  chk_en_n_i,
    output logic                  err_n_o,
    output logic                  err_oe_o
);

    localparam int LANES = ADDR_W / LANE_W;

    logic [0:LANES-1] lane_bad;
    logic             any_bad;
    logic             fire;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            apc_lane_chk #(
                .LANE_W    (LANE_W),
                .ODD_PARITY(ODD_PARITY)
            ) u_lane (
                .lane_i(addr_i[g*LANE_W +: LANE_W]),
                .par_i (apar_i[g]),
                .bad_o (lane_bad[g])
            );
        end
    endgenerate

    always_comb begin
        any_bad = |lane_bad;
        fire    = xfer_start_i & ~chk_en_n_i & any_bad;
    end

    apc_pulse_ctl u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (fire),
        .oe_o   (err_oe_o),
        .lvl_n_o(err_n_o)
    );

    // R5: a disabled checker never drives the pin
    a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en_n_i |=> !err_oe_o);

    // R6: no transfer start, no pulse
    a_r6_no_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_start_i |=> !err_oe_o);

    // R8: the pin is either released high or driven low, never driven high
    a_r8_pin_pairing: assert property (@(posedge clk) disable iff (!rst_n)
        err_oe_o != err_n_o);

    // R2: an address whose bytes are all correct is never flagged
    a_r2_clean_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start_i && !any_bad) |=> !err_oe_o);

endmodule

// File: tb/tb_addr_parity_chk.sv
module tb_addr_parity_chk;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_start_i = 1'b0;
    logic [0:31] addr_i = '0;
    logic [0:3]  apar_i = '0;
    logic        chk_en_n_i = 1'b1;
    logic        err_n_o;
    logic        err_oe_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    addr_parity_chk dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .xfer_start_i(xfer_start_i),
        .addr_i      (addr_i),
        .apar_i      (apar_i),
        .chk_en_n_i  (chk_en_n_i),
        .err_n_o     (err_n_o),
        .err_oe_o    (err_oe_o)
    );

    // fields: address[32], parity flip mask[4], enable_n, start
    localparam int NV = 14;
    localparam logic [37:0] VEC [NV] = '{
        {32'h00000000, 4'b0000, 1'b0, 1'b1},
        {32'hFFFFFFFF, 4'b0000, 1'b0, 1'b1},
        {32'h12345678, 4'b1000, 1'b0, 1'b1},
        {32'h12345678, 4'b0000, 1'b0, 1'b0},
        {32'hA5A5A5A5, 4'b0001, 1'b0, 1'b1},
        {32'hA5A5A5A5, 4'b0100, 1'b0, 1'b1},
        {32'h0F0F0F0F, 4'b1111, 1'b0, 1'b1},
        {32'h0F0F0F0F, 4'b1111, 1'b1, 1'b1},
        {32'hDEADBEEF, 4'b0010, 1'b0, 1'b0},
        {32'hDEADBEEF, 4'b0010, 1'b0, 1'b1},
        {32'h80000001, 4'b0000, 1'b0, 1'b1},
        {32'h80000001, 4'b1001, 1'b1, 1'b0},
        {32'h00FF00FF, 4'b0110, 1'b0, 1'b1},
        {32'h00FF00FF, 4'b0000, 1'b0, 1'b0}
    };

    // odd parity bit for byte n, bit 0 of the bus being the MSB
    function automatic logic good_par(input logic [0:31] a, input int n);
        logic x = 1'b0;
        for (int b = 0; b < 8; b++) x ^= a[8*n + b];
        return ~x;
    endfunction

    function automatic logic [0:3] good_par_all(input logic [0:31] a);
        logic [0:3] p;
        for (int n = 0; n < 4; n++) p[n] = good_par(a, n);
        return p;
    endfunction

    task automatic check(input logic exp_fire, input string tag);
        tests++;
        if (err_oe_o !== exp_fire || err_n_o !== ~exp_fire) begin
            fails++;
            $display("FAIL %s: oe=%b err_n=%b expected oe=%b err_n=%b",
                     tag, err_oe_o, err_n_o, exp_fire, ~exp_fire);
        end
    endtask

    task automatic drive(input logic [0:31] a, input logic [0:3] p,
                         input logic en_n, input logic st);
        addr_i       = a;
        apar_i       = p;
        chk_en_n_i   = en_n;
        xfer_start_i = st;
    endtask

    initial begin
        logic exp_prev;
        logic exp_cur;
        logic [0:31] a;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(1'b0, "R8 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b0, "R8 after reset release");

        // vector table: R2 R3 R4 R5 R6 R7 R9
        exp_prev = 1'b0;
        for (int i = 0; i < NV; i++) begin
            logic [37:0] v;
            v = VEC[i];
            @(negedge clk);
            if (i > 0) check(exp_prev, $sformatf("R2/R3/R4/R5/R6/R7/R9 vector %0d", i - 1));
            drive(v[37:6], good_par_all(v[37:6]) ^ v[5:2], v[1], v[0]);
            exp_cur  = v[0] & ~v[1] & (|v[5:2]);
            exp_prev = exp_cur;
        end
        @(negedge clk);
        check(exp_prev, $sformatf("R2/R3/R4/R7 vector %0d", NV - 1));
        drive(32'h0, 4'h0, 1'b0, 1'b0);
        @(negedge clk);
        check(1'b0, "R4 released after last pulse");

        // R1: flip one bit in byte n, parity computed on the original address
        for (int n = 0; n < 4; n++) begin
            a = 32'h3C5A_9612;
            @(negedge clk);
            drive(a ^ (32'h8000_0000 >> (8*n + 3)), good_par_all(a), 1'b0, 1'b1);
            @(negedge clk);
            check(1'b1, $sformatf("R1 byte %0d bit flip detected", n));
            // same flip, parity bit n flipped too: must be clean
            drive(a ^ (32'h8000_0000 >> (8*n + 3)),
                  good_par_all(a) ^ (4'b1000 >> n), 1'b0, 1'b1);
            @(negedge clk);
            check(1'b0, $sformatf("R1 byte %0d own parity bit compensates", n));
        end

        // R8: asynchronous reset cuts a pulse in flight
        drive(32'h0000_0001, 4'b1111, 1'b0, 1'b1);
        @(negedge clk);
        check(1'b1, "R3 pulse before reset");
        drive(32'h0, 4'h0, 1'b1, 1'b0);
        rst_n = 1'b0;
        #1;
        check(1'b0, "R8 async reset releases pin");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b0, "R8 idle after second reset");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule